// File: doc/BRIEF.md
# Segmented DAC Serial Load Front End

This block is the digital side of a voltage-output converter. A host writes a 16-bit code over a three-wire serial link: an active-low select/load line, a serial clock and a data line. Bits enter a shift register while select is low, one per rising serial-clock edge, most significant bit first. When select returns high after exactly sixteen clocks, the word moves into a separate code latch. A frame with any other clock count is dropped. Only the latch drives the converter switches.

The latched code is split in two. The top four bits are decoded into fifteen equal-weight segment enables in thermometer form. The lower twelve bits are passed out as binary-weighted switch controls. A resolution parameter of 12, 14 or 16 forces the unused low binary controls to zero, so the narrower variants keep the full 16-bit frame. The serial pins are brought into the system clock domain through synchronizers before edge detection. A power-on reset and an asynchronous clear both force the latch to zero code.

Top module: `seg_dac_frontend`

## Requirements
- R1: While `ld_n` is low, each rising edge of `sck` shifts `sdi` into the word register, most significant bit first. A 16-edge frame therefore places the first bit at code bit 15.
- R2: On the rising edge of `ld_n`, the latch takes the word only if exactly 16 `sck` rising edges occurred since `ld_n` fell. A frame with fewer or more edges leaves the outputs unchanged.
- R3: `seg_on[k]` is 1 exactly when the value of code bits 15:12 is greater than k, for k = 0..14, so the enables always form a thermometer pattern.
- R4: `bin_on[i]` equals code bit i for i = 0..11, except that bits below 16-RES are held at 0 (RES=12 zeroes `bin_on[3:0]`).
- R5: Apart from a completed valid frame, a clear or a reset, `seg_on` and `bin_on` hold their values.
- R6: Driving `clr_n` low forces the latch to zero code at once, without waiting for a `clk` edge. A frame that completes while `clr_n` is low is discarded and stays discarded after `clr_n` is released.
- R7: After `rst_n` is asserted, all outputs are 0 until a valid frame loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Asynchronous clear of the code latch, active low |
| ld_n | input | 1 | Serial select; a rising edge requests a load |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| seg_on | output | 15 | Thermometer enables for equal-weight segments |
| bin_on | output | 12 | Binary-weighted switch controls |

## Verification
The bench loads every value of the top nibble against several low-bit patterns. A decoder off by one at either end of the thermometer would light segment 14 at value 14 or leave segment 0 dark at value 1. Frames of 15 and 17 clocks must leave the previous code in place. A counter that does not saturate, or that loads on any select edge, would change the outputs. Clear is checked one nanosecond after it falls, before any clock edge, which catches a synchronous clear. A frame sent while clear is held low is checked to stay discarded after release. A second instance built for 12-bit resolution checks that the low binary controls stay at zero.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_SEG_BITS = 4;
    localparam int unsigned DEF_RES      = 16;
    localparam int unsigned DEF_SYNC     = 2;

    // number of low binary controls forced to zero for a given resolution
    function automatic int unsigned pad_bits(input int unsigned word_w, input int unsigned res);
        return (res >= word_w) ? 0 : word_w - res;
    endfunction
endpackage

// File: rtl/seg_dac_sync.sv
module seg_dac_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/seg_dac_shifter.sv
module seg_dac_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic              load,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              sck_prev;
        logic              ld_prev;
        logic              load;
    } shf_t;

    shf_t st_d, st_q;
    logic sck_rise, ld_rise, ld_fall;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        sck_rise  = sck_s & ~st_q.sck_prev;
        ld_rise   = ld_n_s & ~st_q.ld_prev;
        ld_fall   = ~ld_n_s & st_q.ld_prev;
        st_d.sck_prev = sck_s;
        st_d.ld_prev  = ld_n_s;
        if (ld_fall) begin
            st_d.cnt = '0;
        end else if (!ld_n_s && sck_rise) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], sdi_s};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (ld_rise && st_q.cnt == CNT_FULL) begin
            st_d.load = 1'b1;
            st_d.word = st_q.shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ld_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load = st_q.load;
    assign word = st_q.word;
endmodule

// File: rtl/seg_dac_decode.sv
module seg_dac_decode #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned RES      = 16
) (
    input  logic [WORD_W-1:0]               code,
    output logic [(2**SEG_BITS)-2:0]        seg,
    output logic [WORD_W-SEG_BITS-1:0]      bin
);
    localparam int unsigned SEG_N = (2**SEG_BITS) - 1;
    localparam int unsigned BIN_W = WORD_W - SEG_BITS;
    localparam int unsigned PAD   = seg_dac_pkg::pad_bits(WORD_W, RES);

    logic [SEG_BITS-1:0] msb;
    logic [BIN_W-1:0]    keep;

    assign msb = code[WORD_W-1:BIN_W];

    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        localparam logic [SEG_BITS-1:0] KV = SEG_BITS'(k);
        assign seg[k] = (msb > KV);
    end

    for (genvar i = 0; i < BIN_W; i++) begin : g_mask
        if (i < PAD) begin : g_off
            assign keep[i] = 1'b0;
        end else begin : g_on
            assign keep[i] = 1'b1;
        end
    end

    assign bin = code[BIN_W-1:0] & keep;
endmodule

// File: rtl/seg_dac_frontend.sv
module seg_dac_frontend #(
    parameter int unsigned WORD_W   = seg_dac_pkg::DEF_WORD_W,
    parameter int unsigned SEG_BITS = seg_dac_pkg::DEF_SEG_BITS,
    parameter int unsigned RES      = seg_dac_pkg::DEF_RES,
    parameter int unsigned SYNC     = seg_dac_pkg::DEF_SYNC
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_n,
    input  logic                           ld_n,
    input  logic                           sck,
    input  logic                           sdi,
    output logic [(2**SEG_BITS)-2:0]       seg_on,
    output logic [WORD_W-SEG_BITS-1:0]     bin_on
);
    logic [2:0]        pins_s;
    logic              frame_load;
    logic [WORD_W-1:0] frame_word;
    logic [WORD_W-1:0] code_d, code_q;
    logic              arst_n;

    seg_dac_sync #(
        .W       (3),
        .STAGES  (SYNC),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ld_n, sck, sdi}),
        .dout  (pins_s)
    );

    seg_dac_shifter #(
        .WORD_W (WORD_W)
    ) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_n_s (pins_s[2]),
        .sck_s  (pins_s[1]),
        .sdi_s  (pins_s[0]),
        .load   (frame_load),
        .word   (frame_word)
    );

    // clear and power-on reset share the latch's asynchronous reset
    assign arst_n = rst_n & clr_n;

    always_comb begin
        code_d = code_q;
        if (frame_load) begin
            code_d = frame_word;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    seg_dac_decode #(
        .WORD_W   (WORD_W),
        .SEG_BITS (SEG_BITS),
        .RES      (RES)
    ) u_dec (
        .code (code_q),
        .seg  (seg_on),
        .bin  (bin_on)
    );
endmodule

// File: rtl/seg_dac_checker.sv
module seg_dac_checker #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned SEG_BITS = 4,
    parameter int unsigned RES      = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr_n,
    input logic                       frame_load,
    input logic [(2**SEG_BITS)-2:0]   seg_on,
    input logic [WORD_W-SEG_BITS-1:0] bin_on
);
    localparam int unsigned SEG_N = (2**SEG_BITS) - 1;
    localparam int unsigned PAD   = seg_dac_pkg::pad_bits(WORD_W, RES);

    logic [SEG_N-1:0] seg_inc;
    assign seg_inc = seg_on + SEG_N'(1);

    p_thermo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_inc & seg_on) == '0));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (seg_on == '0 && bin_on == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(clr_n) && !$past(frame_load)) |-> ($stable(seg_on) && $stable(bin_on)));

    p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> !frame_load);

    if (PAD > 0) begin : g_mask_chk
        p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            bin_on[PAD-1:0] == '0);
    end
endmodule

bind seg_dac_frontend seg_dac_checker #(
    .WORD_W   (WORD_W),
    .SEG_BITS (SEG_BITS),
    .RES      (RES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .frame_load (frame_load),
    .seg_on     (seg_on),
    .bin_on     (bin_on)
);

// File: tb/test_seg_dac_frontend.sv
module test_seg_dac_frontend;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic ld_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic [14:0] seg16, seg12;
    logic [11:0] bin16, bin12;
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_code = '0;

    always #5 clk = ~clk;

    seg_dac_frontend i_seg_dac_frontend (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .sck(sck), .sdi(sdi),
        .seg_on(seg16), .bin_on(bin16)
    );

    seg_dac_frontend #(.RES(12)) i_seg_dac_frontend_r12 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .sck(sck), .sdi(sdi),
        .seg_on(seg12), .bin_on(bin12)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // expected outputs computed from the code value
    task automatic check_out(input string req);
        logic [14:0] es;
        logic [11:0] eb;
        for (int k = 0; k < 15; k++) es[k] = (int'(exp_code[15:12]) > k);
        eb = exp_code[11:0];
        check(seg16 === es, req, "seg_on", int'(seg16), int'(es));
        check(bin16 === eb, req, "bin_on", int'(bin16), int'(eb));
        check(seg12 === es, req, "seg_on res12", int'(seg12), int'(es));
        check(bin12 === (eb & 12'hFF0), "R4", "bin_on res12", int'(bin12), int'(eb & 12'hFF0));
    endtask

    task automatic send(input logic [15:0] w, input int nclk);
        ld_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        ld_n = 1'b1;
        wait_clk(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check_out("R7");

        // R1 R3 R4: sweep every top nibble with several low patterns
        for (int n = 0; n < 16; n++) begin
            for (int p = 0; p < 3; p++) begin
                logic [11:0] low;
                low = (p == 0) ? 12'h000 : (p == 1) ? 12'hFFF : 12'(n * 12'h111 ^ 12'hA5A);
                send({n[3:0], low}, 16);
                exp_code = {n[3:0], low};
                check_out("R3");
            end
        end
        send(16'h8001, 16);
        exp_code = 16'h8001;
        check_out("R1");

        // R2: short and long frames are dropped
        send(16'h1234, 15);
        check_out("R2");
        send(16'h4321, 17);
        check_out("R2");
        send(16'hC3C3, 16);
        exp_code = 16'hC3C3;
        check_out("R2");

        // R5: idle serial clock activity with select high changes nothing
        for (int i = 0; i < 6; i++) begin
            sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(4);
        end
        wait_clk(10);
        check_out("R5");

        // R6: clear acts before any clock edge
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        exp_code = '0;
        check_out("R6");
        wait_clk(3);
        clr_n = 1'b1;
        wait_clk(3);
        check_out("R6");

        // R6: frame completing under clear is discarded
        clr_n = 1'b0;
        send(16'hFFFF, 16);
        check_out("R6");
        clr_n = 1'b1;
        wait_clk(10);
        check_out("R6");

        // R7: reset after a load returns to zero
        send(16'h7ABC, 16);
        exp_code = 16'h7ABC;
        check_out("R1");
        rst_n = 1'b0;
        wait_clk(3);
        exp_code = '0;
        check_out("R7");
        rst_n = 1'b1;
        wait_clk(4);
        check_out("R7");
        send(16'hF00F, 16);
        exp_code = 16'hF00F;
        check_out("R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule